// File: doc/BRIEF.md
# Mode-Aware Bidirectional I/O Port with Pin Sharing

This block is an eight-pin general-purpose I/O port. Software reaches it over a simple register bus. An output latch holds the values the pins drive, and a direction register chooses, pin by pin, whether the pin listens or drives. Reading the latch address returns a mix of two sources: the live pad level on listening pins and the latch value on driving pins. Each pin also has a pullup request, which arrives from outside the block. The block lets that pullup through only while the pin is not being driven.

The chip's operating mode is captured while reset is held and stays frozen afterwards. In the two external-bus modes (expanded and special test), the top four pins can be handed over to chip-select signals. The top pin is one of them, and its chip-select enable comes up active after reset, so in these modes that pin starts out driving the program chip-select. In the two internal modes (single-chip and bootstrap), all chip-select requests are ignored. The low four pins can be handed over to PWM channel outputs in any mode.

A pin handed over to another function is always driven from that function's signal, whatever its direction bit says. Its latch value is kept untouched. A build parameter removes the chip-select sharing entirely, for a reduced variant.

Top module: `hport_io`

## Requirements
- R1: Direction bit 0 makes a pin an input (output enable low). Direction bit 1 makes it drive its output latch bit. A write to offset 0x7C loads the latch, and a write to offset 0x7D loads the direction register.
- R2: Reset clears the output latch and the direction register to 0x00. A read of 0x7D after reset returns 0x00.
- R3: After reset, with no PWM enable active, pins 6 to 0 are undriven inputs in all four modes.
- R4: The mode pins are encoded as 00 bootstrap, 01 single-chip, 10 special test and 11 expanded. Bit 1 set means an external-bus mode. Pin 7 takes its chip-select when chip-select enable bit 3 is high and the mode is external-bus. In bootstrap and single-chip, pin 7 stays an undriven input after reset. Dropping enable bit 3 returns pin 7 to its direction bit.
- R5: Chip-select enable bits 2 to 0 hand pins 6 to 4 to chip-select signal bits 2 to 0, but only in the external-bus modes. In the other modes those pins follow their direction bits.
- R6: PWM enable bit n (n = 0..3) forces pin n to drive PWM signal bit n in any mode, whatever its direction bit. The output latch is unchanged by this.
- R7: A read of 0x7C returns the pad level for bits whose direction is 0 and the latch value for bits whose direction is 1.
- R8: A read of 0x7D returns the direction register. A read of any other address returns 0x00. A write to any other address changes neither register.
- R9: A pin's pullup output equals its pullup request while the pin is not driven, and is 0 while the pin is driven.
- R10: The mode is captured only while reset is held. Changes on the mode pins after reset have no effect.
- R11: With the chip-select option removed, the chip-select enables have no effect in any mode, and pins 7 to 4 follow their direction bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| mode_pins | input | 2 | Operating mode, captured during reset |
| bus_addr | input | 8 | Register address |
| bus_wr | input | 1 | Write strobe |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data (combinational on address) |
| pad_in | input | 8 | Pad input levels |
| cs_en | input | 4 | Chip-select enables for pins 7..4 |
| cs_sig | input | 4 | Chip-select values for pins 7..4 |
| pwm_en | input | 4 | PWM enables for pins 3..0 |
| pwm_sig | input | 4 | PWM values for pins 3..0 |
| pu_req | input | 8 | Per-pin pullup requests |
| pad_oe | output | 8 | Per-pin output enable |
| pad_out | output | 8 | Per-pin driven value |
| pad_pu | output | 8 | Per-pin pullup enable |

## Verification
The read path is exercised with direction and pad patterns chosen so that every bit's direction disagrees with its neighbours and the latch differs from the pad. Each wrong source choice therefore shows up as a flipped bit. Chip-select sharing is tried in each mode with the same enables, which separates mode gating from the enables themselves. The reduced build sees the same stimulus in parallel. PWM and pullup cases use alternating enables with latch values that differ from the PWM values, so a pin driven from the wrong source is visible. Each of these cases also checks that the latch survives.

// File: rtl/hport_pkg.sv
// Shared types for the mode-aware I/O port.
// Assumes a two-bit mode code whose upper bit marks external-bus modes.
package hport_pkg;

    typedef enum logic [1:0] {
        HP_MODE_BOOT   = 2'b00,
        HP_MODE_SINGLE = 2'b01,
        HP_MODE_TEST   = 2'b10,
        HP_MODE_EXP    = 2'b11
    } hp_mode_e;

    // True when the mode exposes the external bus (chip selects allowed).
    function automatic logic hp_is_ext(hp_mode_e m);
        return m[1];
    endfunction

endpackage

// File: rtl/hport_regs.sv
// Output latch and direction register of the port.
// Assumes a single-cycle write strobe; both registers reset to zero.
module hport_regs #(
    parameter int W        = 8,
    parameter int AW       = 8,
    parameter logic [AW-1:0] LATCH_ADR = 8'h7C,
    parameter logic [AW-1:0] DIR_ADR   = 8'h7D
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [AW-1:0] bus_addr,
    input  logic          bus_wr,
    input  logic [W-1:0]  bus_wdata,
    output logic [W-1:0]  latch_q,
    output logic [W-1:0]  dir_q
);

    logic hit_latch, hit_dir;

    // Decode which register a write targets.
    always_comb begin
        hit_latch = bus_wr && (bus_addr == LATCH_ADR);
        hit_dir   = bus_wr && (bus_addr == DIR_ADR);
    end

    // Output latch update.
    always_ff @(posedge clk) begin
        if (!rst_n)         latch_q <= '0;
        else if (hit_latch) latch_q <= bus_wdata;
    end

    // Direction register update.
    always_ff @(posedge clk) begin
        if (!rst_n)       dir_q <= '0;
        else if (hit_dir) dir_q <= bus_wdata;
    end

    // R1
    latch_wr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr == LATCH_ADR) |=> latch_q == $past(bus_wdata));

    // R1
    dir_wr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr == DIR_ADR) |=> dir_q == $past(bus_wdata));

    // R8
    foreign_wr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!bus_wr || (bus_addr != LATCH_ADR && bus_addr != DIR_ADR))
        |=> ($stable(latch_q) && $stable(dir_q)));

endmodule

// File: rtl/hport_readback.sv
// Read-data multiplexer: mixes pad levels and latch by direction.
// Assumes combinational read, zero for unmapped addresses.
module hport_readback #(
    parameter int W        = 8,
    parameter int AW       = 8,
    parameter logic [AW-1:0] LATCH_ADR = 8'h7C,
    parameter logic [AW-1:0] DIR_ADR   = 8'h7D
) (
    input  logic [AW-1:0] bus_addr,
    input  logic [W-1:0]  latch_q,
    input  logic [W-1:0]  dir_q,
    input  logic [W-1:0]  pad_in,
    output logic [W-1:0]  bus_rdata
);

    logic [W-1:0] mixed;

    // Per-bit source choice for the latch address.
    always_comb begin
        for (int b = 0; b < W; b++)
            mixed[b] = dir_q[b] ? latch_q[b] : pad_in[b];
    end

    // Address decode for read data.
    always_comb begin
        if (bus_addr == LATCH_ADR)    bus_rdata = mixed;
        else if (bus_addr == DIR_ADR) bus_rdata = dir_q;
        else                          bus_rdata = '0;
    end

    // R8
    always_comb begin
        if (bus_addr != LATCH_ADR && bus_addr != DIR_ADR)
            unmapped_zero_chk: assert (bus_rdata == '0);
    end

endmodule

// File: rtl/hport_pinmux.sv
// Per-pin ownership: GPIO, chip-select (upper pins) or PWM (lower pins).
// Assumes chip-select pins occupy CS_LO..W-1 and PWM pins 0..PWM_N-1.
module hport_pinmux #(
    parameter int W          = 8,
    parameter int CS_LO      = 4,
    parameter int PWM_N      = 4,
    parameter bit CS_PRESENT = 1'b1,
    localparam int CS_N      = W - CS_LO
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ext_mode,
    input  logic [W-1:0]     latch_q,
    input  logic [W-1:0]     dir_q,
    input  logic [CS_N-1:0]  cs_en,
    input  logic [CS_N-1:0]  cs_sig,
    input  logic [PWM_N-1:0] pwm_en,
    input  logic [PWM_N-1:0] pwm_sig,
    input  logic [W-1:0]     pu_req,
    output logic [W-1:0]     pad_oe,
    output logic [W-1:0]     pad_out,
    output logic [W-1:0]     pad_pu
);

    logic unused_cs_inputs;
    assign unused_cs_inputs = ^{cs_en, cs_sig, ext_mode};

    for (genvar i = 0; i < W; i++) begin : g_pin
        logic alt_on, alt_val;

        if (CS_PRESENT && i >= CS_LO) begin : g_cs
            // Chip-select takes the pin only in external-bus modes.
            assign alt_on  = ext_mode & cs_en[i-CS_LO];
            assign alt_val = cs_sig[i-CS_LO];
        end else if (i < PWM_N) begin : g_pwm
            // PWM takes the pin in any mode.
            assign alt_on  = pwm_en[i];
            assign alt_val = pwm_sig[i];
        end else begin : g_plain
            assign alt_on  = 1'b0;
            assign alt_val = 1'b0;
        end

        // Pad drive: alternate source wins over the direction bit.
        always_comb begin
            pad_oe[i]  = alt_on | dir_q[i];
            pad_out[i] = alt_on ? alt_val : latch_q[i];
            pad_pu[i]  = pu_req[i] & ~pad_oe[i];
        end

        if (i < PWM_N) begin : g_pwm_chk
            // R6
            pwm_own_chk: assert property (@(posedge clk) disable iff (!rst_n)
                pwm_en[i] |-> (pad_oe[i] && pad_out[i] == pwm_sig[i]));
        end

        if (i >= CS_LO) begin : g_cs_chk
            // R5
            cs_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
                (!ext_mode || !CS_PRESENT) |-> (pad_oe[i] == dir_q[i]));
        end
    end

    // R9
    pullup_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pad_pu & pad_oe) == '0);

endmodule

// File: rtl/hport_io.sv
// Top of the mode-aware I/O port: mode capture, registers, read path, pin mux.
// Assumes the mode pins are valid while reset is held.
module hport_io
    import hport_pkg::*;
#(
    parameter int W          = 8,
    parameter int AW         = 8,
    parameter int CS_LO      = 4,
    parameter int PWM_N      = 4,
    parameter bit CS_PRESENT = 1'b1,
    parameter logic [AW-1:0] LATCH_ADR = 8'h7C,
    parameter logic [AW-1:0] DIR_ADR   = 8'h7D,
    localparam int CS_N      = W - CS_LO
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [1:0]       mode_pins,
    input  logic [AW-1:0]    bus_addr,
    input  logic             bus_wr,
    input  logic [W-1:0]     bus_wdata,
    output logic [W-1:0]     bus_rdata,
    input  logic [W-1:0]     pad_in,
    input  logic [CS_N-1:0]  cs_en,
    input  logic [CS_N-1:0]  cs_sig,
    input  logic [PWM_N-1:0] pwm_en,
    input  logic [PWM_N-1:0] pwm_sig,
    input  logic [W-1:0]     pu_req,
    output logic [W-1:0]     pad_oe,
    output logic [W-1:0]     pad_out,
    output logic [W-1:0]     pad_pu
);

    hp_mode_e     mode_q;
    logic         ext_mode;
    logic [W-1:0] latch_q, dir_q;

    // Capture the operating mode only while reset is held.
    always_ff @(posedge clk) begin
        if (!rst_n) mode_q <= hp_mode_e'(mode_pins);
    end

    assign ext_mode = hp_is_ext(mode_q);

    hport_regs #(.W(W), .AW(AW), .LATCH_ADR(LATCH_ADR), .DIR_ADR(DIR_ADR)) u_regs (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
        .bus_wdata(bus_wdata), .latch_q(latch_q), .dir_q(dir_q)
    );

    hport_readback #(.W(W), .AW(AW), .LATCH_ADR(LATCH_ADR), .DIR_ADR(DIR_ADR)) u_rd (
        .bus_addr(bus_addr), .latch_q(latch_q), .dir_q(dir_q),
        .pad_in(pad_in), .bus_rdata(bus_rdata)
    );

    hport_pinmux #(.W(W), .CS_LO(CS_LO), .PWM_N(PWM_N), .CS_PRESENT(CS_PRESENT)) u_mux (
        .clk(clk), .rst_n(rst_n), .ext_mode(ext_mode), .latch_q(latch_q),
        .dir_q(dir_q), .cs_en(cs_en), .cs_sig(cs_sig), .pwm_en(pwm_en),
        .pwm_sig(pwm_sig), .pu_req(pu_req), .pad_oe(pad_oe),
        .pad_out(pad_out), .pad_pu(pad_pu)
    );

    // R10
    mode_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> $stable(mode_q));

endmodule

// File: tb/tb_hport_io.sv
`timescale 1ns/1ps
module tb_hport_io;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [1:0] mode_pins = 2'b01;
    logic [7:0] bus_addr = 8'h00, bus_wdata = 8'h00;
    logic       bus_wr = 1'b0;
    logic [7:0] pad_in = 8'h00, pu_req = 8'h00;
    logic [3:0] cs_en = 4'h0, cs_sig = 4'h0, pwm_en = 4'h0, pwm_sig = 4'h0;
    logic [7:0] bus_rdata, pad_oe, pad_out, pad_pu;
    logic [7:0] lite_rdata, lite_oe, lite_out, lite_pu;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    hport_io dut (
        .clk(clk), .rst_n(rst_n), .mode_pins(mode_pins), .bus_addr(bus_addr),
        .bus_wr(bus_wr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .pad_in(pad_in), .cs_en(cs_en), .cs_sig(cs_sig), .pwm_en(pwm_en),
        .pwm_sig(pwm_sig), .pu_req(pu_req), .pad_oe(pad_oe),
        .pad_out(pad_out), .pad_pu(pad_pu)
    );

    hport_io #(.CS_PRESENT(1'b0)) dut_lite (
        .clk(clk), .rst_n(rst_n), .mode_pins(mode_pins), .bus_addr(bus_addr),
        .bus_wr(bus_wr), .bus_wdata(bus_wdata), .bus_rdata(lite_rdata),
        .pad_in(pad_in), .cs_en(cs_en), .cs_sig(cs_sig), .pwm_en(pwm_en),
        .pwm_sig(pwm_sig), .pu_req(pu_req), .pad_oe(lite_oe),
        .pad_out(lite_out), .pad_pu(lite_pu)
    );

    // {dir, latch, pad, expected read of 0x7C}
    localparam logic [31:0] VEC [6] = '{
        32'h00_FF_A5_A5,
        32'hFF_3C_00_3C,
        32'h0F_5A_C3_CA,
        32'hF0_96_69_99,
        32'hAA_FF_00_AA,
        32'h55_00_FF_AA
    };

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%02h expected=%02h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [7:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [7:0] a, output logic [7:0] d);
        bus_addr = a;
        #1 d = bus_rdata;
    endtask

    task automatic do_reset(input logic [1:0] m);
        @(negedge clk);
        rst_n = 1'b0; mode_pins = m;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        #1;
    endtask

    initial begin
        #1_000_000;
        if (!done) begin
            errors++; checks++;
            $display("FAIL watchdog expired");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [7:0] r;
        // R2 R3 R4: reset in single-chip, chip-select enable for pin 7 active
        cs_en = 4'hF; cs_sig = 4'hF;
        do_reset(2'b01);
        rd(8'h7D, r);          chk("R2 dir reset", r, 8'h00);
        pad_in = 8'h00;
        rd(8'h7C, r);          chk("R2 latch reset read", r, 8'h00);
        chk("R3 R4 single-chip oe after reset", pad_oe, 8'h00);
        do_reset(2'b00);
        chk("R4 bootstrap pin7 input", pad_oe, 8'h00);

        // Table walk: R1 R7 in single-chip, no alternates
        cs_en = 4'h0;
        for (int k = 0; k < 6; k++) begin
            wr(8'h7D, VEC[k][31:24]);
            wr(8'h7C, VEC[k][23:16]);
            pad_in = VEC[k][15:8];
            rd(8'h7C, r);
            chk("R7 mixed read", r, VEC[k][7:0]);
            chk("R1 oe follows dir", pad_oe, VEC[k][31:24]);
            chk("R1 driven value", pad_out & pad_oe, VEC[k][23:16] & VEC[k][31:24]);
        end

        // R4 R5 R11: expanded mode
        cs_en = 4'b1000; cs_sig = 4'b1000;
        do_reset(2'b11);
        chk("R4 expanded pin7 oe", pad_oe, 8'h80);
        chk("R4 expanded pin7 value", pad_out & 8'h80, 8'h80);
        chk("R3 expanded pins 6..0 input", pad_oe & 8'h7F, 8'h00);
        cs_sig = 4'b0000; #1;
        chk("R4 pin7 follows chip-select", pad_out & 8'h80, 8'h00);
        cs_en = 4'hF; cs_sig = 4'b0101; #1;
        chk("R5 expanded cs pins oe", pad_oe, 8'hF0);
        chk("R5 expanded cs values", pad_out & 8'hF0, 8'h50);
        chk("R11 reduced ignores cs", lite_oe, 8'h00);
        mode_pins = 2'b01;
        repeat (2) @(negedge clk);
        #1 chk("R10 mode frozen after reset", pad_oe, 8'hF0);
        cs_en = 4'h0; #1;
        chk("R4 pin7 released to gpio", pad_oe, 8'h00);

        // R5: special test mode, only lower chip selects
        cs_en = 4'b0111;
        do_reset(2'b10);
        chk("R5 test mode cs pins", pad_oe, 8'h70);
        do_reset(2'b01);
        chk("R5 single-chip ignores cs", pad_oe, 8'h00);
        cs_en = 4'h0;

        // R6: PWM overrides direction, latch kept
        wr(8'h7C, 8'h0F);
        pwm_en = 4'b0101; pwm_sig = 4'b0001; #1;
        chk("R6 pwm oe", pad_oe, 8'h05);
        chk("R6 pwm values", pad_out & 8'h05, 8'h01);
        do_reset(2'b00);
        chk("R3 reset with pwm only", pad_oe, 8'h05);
        wr(8'h7C, 8'h0F);
        pwm_en = 4'h0;
        wr(8'h7D, 8'h0F);
        pad_in = 8'h00;
        rd(8'h7C, r);          chk("R6 latch kept under pwm", r, 8'h0F);

        // R9: pullup gating
        pu_req = 8'hFF;
        wr(8'h7D, 8'hF0);
        #1 chk("R9 pullup inputs only", pad_pu, 8'h0F);
        pwm_en = 4'b0001; #1;
        chk("R9 pullup off on pwm pin", pad_pu, 8'h0E);
        pwm_en = 4'h0;

        // R8: unmapped address
        wr(8'h7E, 8'hFF);
        rd(8'h7D, r);          chk("R8 dir unchanged", r, 8'hF0);
        pad_in = 8'h00;
        rd(8'h7C, r);          chk("R8 latch unchanged", r, 8'h00);
        rd(8'h7E, r);          chk("R8 unmapped reads zero", r, 8'h00);

        done = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule